// File: doc/BRIEF.md
# Special Function Register Decoder

This block sits in front of the data register file of a small 8-bit microcontroller core. Each cycle it takes one operand read address and one write (address, data, strobe) in the low part of the data space. It works out which physical resource each address refers to, returns the read byte, and issues exactly one write strobe toward the chosen resource. The core registers it owns are the file select pointer, the working register, the status byte and the option byte. The timer, the I/O port latches, general-purpose RAM and the program-counter sequencer sit outside the block and are reached through simple read and write ports.

Address 0 holds no storage. It redirects the access through the file select pointer. Address 1 is shared between the timer and the working register, and an option bit selects which one it reaches. A write whose target is the program-counter low byte produces a full jump target: the written byte forms the low bits, the status page bits form the top bits, and bit 8 depends on the kind of instruction. Some port addresses can be turned into plain RAM by a parameter, so the same block serves smaller pin-count variants.

Top module: `sfr_front`

## Requirements
- R1: After reset the file select pointer, working register and status byte are 0 and the option byte is 0xFF, so address 1 reaches the timer.
- R2: Direct addresses decode as 1 = timer or working register, 2 = program-counter low byte (read from `pc_low_in`), 3 = status, 4 = file select pointer, and 5 to 9 = port bytes 0 to 4 (port k is byte k of `io_rd_data`). Addresses 10 to 31 go to the RAM port at the same address.
- R3: A read or write at address 0 acts on the resource at the address held in the low 5 bits of the file select pointer.
- R4: If the file select pointer's low 5 bits are 0, an indirect read returns 0 and an indirect write raises no strobe and changes no state.
- R5: When option bit 7 is 1, address 1 reads `tmr_rd_data` and a write raises `tmr_we`. When the bit is 0, address 1 reads and writes the working register and the timer is untouched.
- R6: `w_we` loads the working register from `w_wd`. If a register-file write to the working register happens in the same cycle, the register-file write wins.
- R7: A write that resolves to address 2 raises `pc_load` in the same cycle, with `pc_load_val` = {status[7:6], b8, write data}. `instr_kind` is 0 for other, 1 for a call and 2 for a jump (3 acts as other). b8 is `op_bit8` for a jump and 0 for every other kind.
- R8: Port indices whose bit is set in `IO_AS_RAM` (default 5'b11000: ports 3 and 4) are served by the RAM port. For those addresses `io_we` stays low.
- R9: A read and a write in the same cycle behave as read-before-write. Internal registers take the new value at the next clock edge.
- R10: A write raises at most one strobe, and nothing is strobed while `wr_en` is 0.
- R11: `opt_we` loads the option byte from `opt_wd`. The new address-1 mapping applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_addr | input | 5 | Operand read address |
| rd_data | output | 8 | Resolved read byte |
| wr_en | input | 1 | Register-file write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| instr_kind | input | 2 | 0 other, 1 call, 2 jump |
| op_bit8 | input | 1 | Opcode bit used as PC bit 8 for jumps |
| w_we | input | 1 | Direct working-register load |
| w_wd | input | 8 | Data for direct load |
| wreg_q | output | 8 | Working register |
| opt_we | input | 1 | Option byte load |
| opt_wd | input | 8 | Option byte data |
| option_q | output | 8 | Option byte |
| status_q | output | 8 | Status byte |
| pc_low_in | input | 8 | Current PC low byte |
| pc_load | output | 1 | Jump target valid |
| pc_load_val | output | 11 | Jump target |
| tmr_rd_data | input | 8 | Timer value |
| tmr_we | output | 1 | Timer write strobe |
| tmr_wd | output | 8 | Timer write data |
| io_rd_data | input | 40 | Port latch bytes, port k at bits 8k+7:8k |
| io_we | output | 5 | Per-port write strobes |
| io_wd | output | 8 | Port write data |
| ram_raddr | output | 5 | RAM read address |
| ram_rdata | input | 8 | RAM read data |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | 5 | RAM write address |
| ram_wdata | output | 8 | RAM write data |

## Verification
The hardest case to reach is an indirect access through a pointer that itself resolves to a special location. Examples are the pointer aimed at address 1 while the option bit is clear, at address 2 so that an indirect write becomes a jump, or at 0 so that the access must fall silent. Random stimulus rarely lines these up. The stimulus therefore biases pointer writes toward the low ten addresses and toggles the option bit now and then. Directed sequences load the pointer with 0, 1, 2 and a RAM-mapped port address before they issue indirect reads and writes.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned DW = 8;

  // Fixed addresses the core decodes by value
  localparam int unsigned A_INDIR = 0;
  localparam int unsigned A_TMRW  = 1;
  localparam int unsigned A_PCLO  = 2;
  localparam int unsigned A_STAT  = 3;
  localparam int unsigned A_PTR   = 4;
  localparam int unsigned A_PORT0 = 5;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_TMR, TGT_WREG, TGT_PCL, TGT_STAT, TGT_PTR, TGT_IO, TGT_RAM
  } tgt_e;

  typedef enum logic [1:0] {
    K_OTHER = 2'd0,
    K_CALL  = 2'd1,
    K_JUMP  = 2'd2
  } kind_e;

  // PC bit 8 selection for a write into the PC low byte
  function automatic logic pc_bit8(input logic [1:0] kind, input logic opb);
    return (kind == K_JUMP) ? opb : 1'b0;
  endfunction
endpackage

// File: rtl/sfr_addr_resolve.sv
module sfr_addr_resolve
  import sfr_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter int unsigned NUM_IO    = 5,
  parameter logic [NUM_IO-1:0] IO_AS_RAM = '0,
  localparam int unsigned IOW      = (NUM_IO > 1) ? $clog2(NUM_IO) : 1
) (
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  ptr_lo,
  input  logic           rtw,
  output logic [AW-1:0]  eff,
  output logic           indirect,
  output logic           is_null,
  output tgt_e           tgt,
  output logic [IOW-1:0] io_idx
);
  assign indirect = (addr == AW'(A_INDIR));
  assign eff      = indirect ? ptr_lo : addr;
  assign is_null  = (eff == AW'(A_INDIR));

  always_comb begin
    tgt    = TGT_RAM;
    io_idx = '0;
    if (is_null)                   tgt = TGT_NONE;
    else if (eff == AW'(A_TMRW))   tgt = rtw ? TGT_TMR : TGT_WREG;
    else if (eff == AW'(A_PCLO))   tgt = TGT_PCL;
    else if (eff == AW'(A_STAT))   tgt = TGT_STAT;
    else if (eff == AW'(A_PTR))    tgt = TGT_PTR;
    else begin
      for (int i = 0; i < NUM_IO; i++) begin
        if (eff == AW'(A_PORT0 + i)) begin
          io_idx = IOW'(i);
          tgt    = IO_AS_RAM[i] ? TGT_RAM : TGT_IO;
        end
      end
    end
  end
endmodule

// File: rtl/sfr_core_regs.sv
module sfr_core_regs
  import sfr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          ptr_we,
  input  logic          wreg_fwe,
  input  logic          stat_we,
  input  logic          w_we,
  input  logic [DW-1:0] w_wd,
  input  logic          opt_we,
  input  logic [DW-1:0] opt_wd,
  output logic [DW-1:0] ptr_q,
  output logic [DW-1:0] wreg_q,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] option_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      wreg_q   <= '0;
      status_q <= '0;
      option_q <= '1;
    end else begin
      if (ptr_we)        ptr_q  <= wr_data;
      if (wreg_fwe)      wreg_q <= wr_data;
      else if (w_we)     wreg_q <= w_wd;
      if (stat_we)       status_q <= wr_data;
      if (opt_we)        option_q <= opt_wd;
    end
  end

  // R6: register-file write beats the direct load
  a_r6_file_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wreg_fwe && w_we) |=> (wreg_q == $past(wr_data)));

  // R9: pointer write visible one edge later
  a_r9_ptr_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (ptr_q == $past(wr_data)));

  // R11: option load
  a_r11_opt_load: assert property (@(posedge clk) disable iff (!rst_n)
    opt_we |=> (option_q == $past(opt_wd)));
endmodule

// File: rtl/sfr_pc_load.sv
module sfr_pc_load
  import sfr_pkg::*;
#(
  parameter int unsigned PCW = 11,
  localparam int unsigned PAGE_W = PCW - DW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic [1:0]     kind,
  input  logic           op_bit8,
  input  logic [DW-1:0]  status_q,
  input  logic [DW-1:0]  wr_data,
  output logic           pc_load,
  output logic [PCW-1:0] pc_load_val
);
  function automatic logic [PCW-1:0] jump_target(
    input logic [DW-1:0] st, input logic [1:0] k, input logic ob, input logic [DW-1:0] lo);
    return {st[DW-1 -: PAGE_W], pc_bit8(k, ob), lo};
  endfunction

  assign pc_load     = hit;
  assign pc_load_val = jump_target(status_q, kind, op_bit8, wr_data);

  // R7: a call always clears bit 8
  a_r7_call_b8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && kind == K_CALL) |-> !pc_load_val[DW]);

  // R7: the low byte carries the written data
  a_r7_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_load_val[DW-1:0] == wr_data));
endmodule

// File: rtl/sfr_front.sv
module sfr_front
  import sfr_pkg::*;
#(
  parameter int unsigned AW     = 5,
  parameter int unsigned NUM_IO = 5,
  parameter logic [NUM_IO-1:0] IO_AS_RAM = 5'b11000,
  parameter int unsigned PCW    = 11,
  localparam int unsigned IOW   = (NUM_IO > 1) ? $clog2(NUM_IO) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        rd_addr,
  output logic [7:0]           rd_data,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [1:0]           instr_kind,
  input  logic                 op_bit8,
  input  logic                 w_we,
  input  logic [7:0]           w_wd,
  output logic [7:0]           wreg_q,
  input  logic                 opt_we,
  input  logic [7:0]           opt_wd,
  output logic [7:0]           option_q,
  output logic [7:0]           status_q,
  input  logic [7:0]           pc_low_in,
  output logic                 pc_load,
  output logic [PCW-1:0]       pc_load_val,
  input  logic [7:0]           tmr_rd_data,
  output logic                 tmr_we,
  output logic [7:0]           tmr_wd,
  input  logic [NUM_IO*8-1:0]  io_rd_data,
  output logic [NUM_IO-1:0]    io_we,
  output logic [7:0]           io_wd,
  output logic [AW-1:0]        ram_raddr,
  input  logic [7:0]           ram_rdata,
  output logic                 ram_we,
  output logic [AW-1:0]        ram_waddr,
  output logic [7:0]           ram_wdata
);
  logic [DW-1:0]  ptr_q;
  logic           rtw;
  logic [AW-1:0]  rd_eff, wr_eff;
  logic           rd_ind, wr_ind, rd_null, wr_null;
  tgt_e           rd_tgt, wr_tgt;
  logic [IOW-1:0] rd_io_idx, wr_io_idx;
  logic           wr_go, ptr_we, wreg_fwe, stat_we, pcl_hit;
  logic [DW-1:0]  io_byte [NUM_IO];
  logic [DW-1:0]  io_rd_sel;

  assign rtw = option_q[DW-1];

  sfr_addr_resolve #(.AW(AW), .NUM_IO(NUM_IO), .IO_AS_RAM(IO_AS_RAM)) u_rd_res (
    .addr(rd_addr), .ptr_lo(ptr_q[AW-1:0]), .rtw(rtw),
    .eff(rd_eff), .indirect(rd_ind), .is_null(rd_null), .tgt(rd_tgt), .io_idx(rd_io_idx));

  sfr_addr_resolve #(.AW(AW), .NUM_IO(NUM_IO), .IO_AS_RAM(IO_AS_RAM)) u_wr_res (
    .addr(wr_addr), .ptr_lo(ptr_q[AW-1:0]), .rtw(rtw),
    .eff(wr_eff), .indirect(wr_ind), .is_null(wr_null), .tgt(wr_tgt), .io_idx(wr_io_idx));

  // Unpack port bytes
  for (genvar g = 0; g < NUM_IO; g++) begin : g_io
    assign io_byte[g] = io_rd_data[g*DW +: DW];
    assign io_we[g]   = wr_go && (wr_tgt == TGT_IO) && (wr_io_idx == IOW'(g));
  end

  always_comb begin
    io_rd_sel = '0;
    for (int i = 0; i < NUM_IO; i++)
      if (rd_io_idx == IOW'(i)) io_rd_sel = io_byte[i];
  end

  // Read mux: combinational, sees the pre-write state
  always_comb begin
    unique case (rd_tgt)
      TGT_TMR:  rd_data = tmr_rd_data;
      TGT_WREG: rd_data = wreg_q;
      TGT_PCL:  rd_data = pc_low_in;
      TGT_STAT: rd_data = status_q;
      TGT_PTR:  rd_data = ptr_q;
      TGT_IO:   rd_data = io_rd_sel;
      TGT_RAM:  rd_data = ram_rdata;
      default:  rd_data = '0;
    endcase
  end

  // Write strobes
  assign wr_go     = wr_en && !wr_null;
  assign ptr_we    = wr_go && (wr_tgt == TGT_PTR);
  assign wreg_fwe  = wr_go && (wr_tgt == TGT_WREG);
  assign stat_we   = wr_go && (wr_tgt == TGT_STAT);
  assign pcl_hit   = wr_go && (wr_tgt == TGT_PCL);
  assign tmr_we    = wr_go && (wr_tgt == TGT_TMR);
  assign ram_we    = wr_go && (wr_tgt == TGT_RAM);
  assign tmr_wd    = wr_data;
  assign io_wd     = wr_data;
  assign ram_wdata = wr_data;
  assign ram_waddr = wr_eff;
  assign ram_raddr = rd_eff;

  sfr_core_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .ptr_we(ptr_we), .wreg_fwe(wreg_fwe), .stat_we(stat_we),
    .w_we(w_we), .w_wd(w_wd), .opt_we(opt_we), .opt_wd(opt_wd),
    .ptr_q(ptr_q), .wreg_q(wreg_q), .status_q(status_q), .option_q(option_q));

  sfr_pc_load #(.PCW(PCW)) u_pc (
    .clk(clk), .rst_n(rst_n), .hit(pcl_hit), .kind(instr_kind), .op_bit8(op_bit8),
    .status_q(status_q), .wr_data(wr_data), .pc_load(pc_load), .pc_load_val(pc_load_val));

  // R10: at most one target per write
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_we, |io_we, ram_we, pc_load, ptr_we, wreg_fwe, stat_we}));

  // R10: idle port strobes nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !(tmr_we || (|io_we) || ram_we || pc_load || ptr_we || wreg_fwe || stat_we));

  // R4: a null indirect write is silent and leaves the pointer alone
  a_r4_null_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ind && ptr_q[AW-1:0] == '0) |=> $stable(ptr_q));

  // R4: a null indirect read returns 0
  a_r4_null_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ind && ptr_q[AW-1:0] == '0) |-> (rd_data == '0));

  // R5: with the timer mapped, an address-1 write leaves the working register alone
  a_r5_wreg_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eff == AW'(A_TMRW) && rtw && !w_we) |=> $stable(wreg_q));

  // R8: ports mapped as RAM never strobe their latch
  a_r8_ram_ports_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we & IO_AS_RAM) == '0);
endmodule

// File: tb/sfr_front_tb.sv
module sfr_front_tb;
  localparam int AW = 5, NIO = 5, PCW = 11;
  localparam logic [NIO-1:0] RAMPORT = 5'b11000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] rd_data, wr_data = '0, w_wd = '0, opt_wd = '0;
  logic wr_en = 0, op_bit8 = 0, w_we = 0, opt_we = 0;
  logic [1:0] instr_kind = '0;
  logic [7:0] wreg_q, option_q, status_q, pc_low_in = 8'h5A;
  logic pc_load, tmr_we, ram_we;
  logic [PCW-1:0] pc_load_val;
  logic [7:0] tmr_rd_data, tmr_wd, io_wd, ram_rdata, ram_wdata;
  logic [NIO*8-1:0] io_rd_data;
  logic [NIO-1:0] io_we;
  logic [AW-1:0] ram_raddr, ram_waddr;

  // Bench-side model state
  logic [7:0] m_ptr, m_w, m_st, m_opt, m_tmr;
  logic [7:0] m_io [NIO];
  logic [7:0] m_mem [32];
  int vectors = 0, fails = 0;

  assign tmr_rd_data = m_tmr;
  assign ram_rdata   = m_mem[ram_raddr];
  always_comb for (int i = 0; i < NIO; i++) io_rd_data[i*8 +: 8] = m_io[i];

  sfr_front u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int e_addr(input logic [AW-1:0] a);
    return (a == 0) ? int'(m_ptr[4:0]) : int'(a);
  endfunction

  function automatic logic [7:0] e_read(input logic [AW-1:0] a);
    int e = e_addr(a);
    if (e == 0) return 8'h00;
    if (e == 1) return m_opt[7] ? m_tmr : m_w;
    if (e == 2) return pc_low_in;
    if (e == 3) return m_st;
    if (e == 4) return m_ptr;
    if (e >= 5 && e <= 9 && !RAMPORT[e-5]) return m_io[e-5];
    return m_mem[e];
  endfunction

  // Check one cycle's outputs, then advance the model across the edge
  task automatic step;
    int e;
    logic [7:0] n_ptr, n_w, n_st, n_opt, n_tmr;
    logic [NIO-1:0] x_io;
    logic x_tmr, x_ram, x_pc;
    #1;
    e = e_addr(wr_addr);
    x_tmr = wr_en && e == 1 && m_opt[7];
    x_pc  = wr_en && e == 2;
    x_io  = '0;
    if (wr_en && e >= 5 && e <= 9 && !RAMPORT[e-5]) x_io[e-5] = 1'b1;
    x_ram = wr_en && e != 0 && ((e >= 10) || (e >= 5 && e <= 9 && RAMPORT[e-5]));
    chk(rd_addr == 0 ? "R3 indirect read" : "R2 read", {24'd0, rd_data}, {24'd0, e_read(rd_addr)});
    chk("R5 timer strobe", {31'd0, tmr_we}, {31'd0, x_tmr});
    chk("R8 port strobes", {27'd0, io_we}, {27'd0, x_io});
    chk("R2 ram strobe", {31'd0, ram_we}, {31'd0, x_ram});
    chk("R7 pc strobe", {31'd0, pc_load}, {31'd0, x_pc});
    if (x_ram) chk("R3 ram addr", {27'd0, ram_waddr}, e);
    if (x_pc)
      chk("R7 target", {21'd0, pc_load_val},
          {21'd0, m_st[7:6], (instr_kind == 2'd2) ? op_bit8 : 1'b0, wr_data});
    n_ptr = m_ptr; n_w = m_w; n_st = m_st; n_opt = m_opt; n_tmr = m_tmr;
    if (w_we) n_w = w_wd;
    if (wr_en && e != 0) begin
      if (e == 1) begin if (m_opt[7]) n_tmr = wr_data; else n_w = wr_data; end
      else if (e == 3) n_st = wr_data;
      else if (e == 4) n_ptr = wr_data;
    end
    if (opt_we) n_opt = opt_wd;
    @(posedge clk);
    #1;
    if (x_ram) m_mem[e] = wr_data;
    for (int i = 0; i < NIO; i++) if (x_io[i]) m_io[i] = wr_data;
    m_ptr = n_ptr; m_w = n_w; m_st = n_st; m_opt = n_opt; m_tmr = n_tmr;
    @(negedge clk);
    chk("R6 R1 wreg", {24'd0, wreg_q}, {24'd0, m_w});
    chk("R11 option", {24'd0, option_q}, {24'd0, m_opt});
    chk("R9 status", {24'd0, status_q}, {24'd0, m_st});
  endtask

  task automatic idle;
    wr_en = 0; w_we = 0; opt_we = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    idle(); wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20251));
    m_ptr = 0; m_w = 0; m_st = 0; m_opt = 8'hFF; m_tmr = 8'h3C;
    for (int i = 0; i < NIO; i++) m_io[i] = 8'h10 + 8'(i);
    for (int i = 0; i < 32; i++) m_mem[i] = 8'(i * 7 + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen through the ports
    rd_addr = 5'd4; #1; chk("R1 ptr reset", {24'd0, rd_data}, 0);
    rd_addr = 5'd1; #1; chk("R1 addr1 is timer", {24'd0, rd_data}, {24'd0, 8'h3C});
    chk("R1 option reset", {24'd0, option_q}, {24'd0, 8'hFF});
    chk("R1 wreg reset", {24'd0, wreg_q}, 0);
    // R4: pointer 0, indirect read and write stay silent
    rd_addr = 5'd0; wr(5'd0, 8'hAB);
    rd_addr = 5'd4; step();
    // R5: clear the option bit, address 1 becomes the working register
    idle(); opt_we = 1; opt_wd = 8'h7F; step();
    rd_addr = 5'd1; wr(5'd1, 8'hC3);
    rd_addr = 5'd1; step();
    // R3: pointer at 1 reaches the working register indirectly
    wr(5'd4, 8'h01);
    rd_addr = 5'd0; wr(5'd0, 8'h99);
    // R9: read-before-write on the same address
    rd_addr = 5'd3; wr(5'd3, 8'hC0);
    rd_addr = 5'd3; step();
    // R7: indirect write to PC low byte, all kinds
    wr(5'd4, 8'h02);
    for (int k = 0; k < 4; k++) begin
      idle(); wr_en = 1; wr_addr = 0; wr_data = 8'(k * 17);
      instr_kind = 2'(k); op_bit8 = 1'b1; step();
    end
    // R8: pointer at a RAM-mapped port and a real port
    wr(5'd4, 8'h08); wr(5'd0, 8'h44);
    rd_addr = 5'd8; step();
    wr(5'd4, 8'hE6); wr(5'd0, 8'h55);
    rd_addr = 5'd6; step();
    // R6: simultaneous direct load and file write to the working register
    idle(); wr_en = 1; wr_addr = 5'd1; wr_data = 8'h12; w_we = 1; w_wd = 8'h34; step();
    idle(); w_we = 1; w_wd = 8'h56; step();
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      rd_addr    = 5'($urandom_range(0, 31));
      wr_en      = ($urandom_range(0, 9) < 7);
      wr_addr    = ($urandom_range(0, 9) < 5) ? 5'($urandom_range(0, 9)) : 5'($urandom_range(0, 31));
      wr_data    = (wr_addr == 5'd4 && $urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 9))
                                                                  : 8'($urandom);
      instr_kind = 2'($urandom_range(0, 3));
      op_bit8    = 1'($urandom);
      w_we       = ($urandom_range(0, 9) < 2);
      w_wd       = 8'($urandom);
      opt_we     = ($urandom_range(0, 19) == 0);
      opt_wd     = 8'($urandom);
      pc_low_in  = 8'($urandom);
      step();
    end
    idle();
    finish_run();
  end
endmodule